// File: doc/BRIEF.md
# Skew-Tolerant Rotating-Slot Transfer Buffer

This block carries a stream of words between two clock domains that share a frequency but can be far apart in phase. Each cycle the incoming word lands in the next register slot of a small ring. The read side takes every slot back out, through an output mux, a fixed number of cycles after it was filled. The gap between a slot's write and its read is the margin that absorbs the skew and jitter between the two domains.

The number of slots in use, called the active depth D, is set by a configuration input. A deeper ring tolerates more skew but adds latency. D can be lowered after manufacture to win back latency where the measured skew allows. The write index and the read index step through the ring in lockstep, and the read index stays one slot ahead of the write index modulo D. There is no full/empty handshake: a slot is filled on every cycle, and a cycle with no valid input fills its slot with an invalid marker. For implementation and simulation, both sides run from one clock. Reset lines up both indices and loads the depth.

Top module: `skew_slot_fifo`

## Requirements
- R1: While reset is high, and for the first D-1 cycles after it is released, rd_valid is 0.
- R2: Edge 0 is the first rising edge with rst low, and edge k is the k-th edge after it. A word sampled with wr_valid=1 at edge k appears on rd_data with rd_valid=1 just after edge k+D-1, so the latency is D-1 cycles.
- R3: A continuous stream of valid words leaves in the order it was written, one word every cycle, with no gaps and no repeats.
- R4: A slot is used every cycle whether or not wr_valid is high. A cycle sampled with wr_valid=0 produces rd_valid=0 exactly D-1 cycles later and does not shift the timing of later words.
- R5: D is taken from cfg_depth on every rising edge while rst is high. A value below 2 gives D=2, a value above MAX_DEPTH (default 8) gives D=MAX_DEPTH, and any value in between is used as is.
- R6: Changes on cfg_depth while rst is low have no effect on D or on the latency.
- R7: The write slot index advances by one every cycle and wraps from D-1 to 0. The read slot index always equals the write slot index plus one, modulo D, so each slot is read one cycle before it is overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst | input | 1 | Synchronous active-high reset; aligns the indices and loads the depth |
| cfg_depth | input | DEP_W (4) | Requested number of active slots, sampled only during reset |
| wr_valid | input | 1 | Incoming word is valid |
| wr_data | input | DATA_W (16) | Incoming word |
| rd_valid | output | 1 | Outgoing word is valid |
| rd_data | output | DATA_W (16) | Outgoing word, meaningful when rd_valid is 1 |

## Verification
The bench uses four kinds of input pattern, and each one rules out a different fault:
- An unbroken run of distinct words fixes the exact latency and shows that no word is lost, duplicated or reordered.
- A stream with periodic holes in wr_valid shows that a slot is consumed on every cycle, valid or not: an empty cycle must come out as an invalid cycle D-1 cycles later, not be skipped.
- Runs at depths 3, 2 and 8, and at out-of-range requests, separate correct wrapping and clamping from designs that only work at the default depth.
- Changing cfg_depth in the middle of a stream shows that the depth is latched only at reset.

// File: rtl/skew_slot_pkg.sv
package skew_slot_pkg;

   localparam int unsigned MIN_SLOTS = 2;

   // Limit a requested slot count to the legal range [MIN_SLOTS, lim].
   function automatic int unsigned clamp_depth(input int unsigned req,
                                               input int unsigned lim);
      if (req < MIN_SLOTS) return MIN_SLOTS;
      if (req > lim)       return lim;
      return req;
   endfunction

endpackage

// File: rtl/slot_ring_ptr.sv
module slot_ring_ptr #(
   parameter int unsigned IDX_W = 3,
   parameter int unsigned DEP_W = 4,
   parameter int unsigned START = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DEP_W-1:0] depth,
   output logic [IDX_W-1:0] idx
);

   logic last_slot;

   assign last_slot = (DEP_W'(idx) == depth - DEP_W'(1));

   always_ff @(posedge clk) begin
      if (rst)            idx <= IDX_W'(START);
      else if (last_slot) idx <= '0;
      else                idx <= idx + IDX_W'(1);
   end

endmodule

// File: rtl/slot_bank.sv
module slot_bank #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned SLOTS     = 8,
   parameter int unsigned IDX_W     = 3,
   parameter bit          ONEHOT_RD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   logic              slot_v [SLOTS];
   logic [DATA_W-1:0] slot_d [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = (wr_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (rst)      slot_v[s] <= 1'b0;
         else if (hit) slot_v[s] <= wr_valid;
      end

      always_ff @(posedge clk) begin
         if (!rst && hit) slot_d[s] <= wr_data;
      end
   end

   if (ONEHOT_RD) begin : g_rd_andor
      always_comb begin
         rd_valid = 1'b0;
         rd_data  = '0;
         for (int s = 0; s < SLOTS; s++) begin
            if (rd_idx == IDX_W'(s)) begin
               rd_valid = rd_valid | slot_v[s];
               rd_data  = rd_data  | slot_d[s];
            end
         end
      end
   end else begin : g_rd_index
      assign rd_valid = slot_v[rd_idx];
      assign rd_data  = slot_d[rd_idx];
   end

endmodule

// File: rtl/skew_slot_fifo.sv
module skew_slot_fifo #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned MAX_DEPTH = 8,
   parameter bit          ONEHOT_RD = 1'b1,
   parameter int unsigned DEP_W     = $clog2(MAX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DEP_W-1:0]  cfg_depth,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned IDX_W = $clog2(MAX_DEPTH);

   if (MAX_DEPTH < skew_slot_pkg::MIN_SLOTS) begin : g_bad_depth
      initial $error("skew_slot_fifo: MAX_DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      initial $error("skew_slot_fifo: DATA_W must be positive");
   end

   logic [DEP_W-1:0]  depth_q;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  rd_idx;
   logic              bank_v;
   logic [DATA_W-1:0] bank_d;

   // Depth is latched only while reset is held, keeping the indices coherent.
   always_ff @(posedge clk) begin
      if (rst) depth_q <= DEP_W'(skew_slot_pkg::clamp_depth(32'(cfg_depth), MAX_DEPTH));
   end

   slot_ring_ptr #(.IDX_W(IDX_W), .DEP_W(DEP_W), .START(0)) u_wr_ptr (
      .clk(clk), .rst(rst), .depth(depth_q), .idx(wr_idx)
   );

   // Read index starts one slot ahead: the offset is D-1 behind the writer.
   slot_ring_ptr #(.IDX_W(IDX_W), .DEP_W(DEP_W), .START(1)) u_rd_ptr (
      .clk(clk), .rst(rst), .depth(depth_q), .idx(rd_idx)
   );

   slot_bank #(
      .DATA_W(DATA_W), .SLOTS(MAX_DEPTH), .IDX_W(IDX_W), .ONEHOT_RD(ONEHOT_RD)
   ) u_bank (
      .clk(clk), .rst(rst),
      .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_valid(bank_v), .rd_data(bank_d)
   );

   always_ff @(posedge clk) begin
      if (rst) rd_valid <= 1'b0;
      else     rd_valid <= bank_v;
   end

   always_ff @(posedge clk) begin
      rd_data <= bank_d;
   end

endmodule

// File: rtl/skew_slot_fifo_chk.sv
module skew_slot_fifo_chk #(
   parameter int unsigned MAX_DEPTH = 8,
   parameter int unsigned DEP_W     = $clog2(MAX_DEPTH + 1),
   parameter int unsigned IDX_W     = $clog2(MAX_DEPTH)
) (
   input logic             clk,
   input logic             rst,
   input logic [DEP_W-1:0] depth_q,
   input logic [IDX_W-1:0] wr_idx,
   input logic [IDX_W-1:0] rd_idx,
   input logic             rd_valid
);

   // Cycles since reset release, saturating once past the largest depth.
   logic [DEP_W-1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                               since_rst <= '0;
      else if (since_rst != DEP_W'(MAX_DEPTH)) since_rst <= since_rst + DEP_W'(1);
   end

   logic [DEP_W-1:0] wr_last;
   logic [DEP_W-1:0] wr_succ;
   assign wr_last = depth_q - DEP_W'(1);
   assign wr_succ = (DEP_W'(wr_idx) == wr_last) ? '0 : DEP_W'(wr_idx) + DEP_W'(1);

   // R1: no output before the first word has had time to cross
   a_r1_quiet_fill: assert property (@(posedge clk) disable iff (rst)
      (since_rst < depth_q) |-> !rd_valid);

   // R5: latched depth within the legal range
   a_r5_depth_range: assert property (@(posedge clk) disable iff (rst)
      (depth_q >= DEP_W'(2)) && (depth_q <= DEP_W'(MAX_DEPTH)));

   // R6: depth frozen outside reset
   a_r6_depth_hold: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(depth_q));

   // R7: read index one ahead of write index modulo depth
   a_r7_rd_ahead: assert property (@(posedge clk) disable iff (rst)
      DEP_W'(rd_idx) == wr_succ);

   // R7: write index steps by one and wraps at depth-1
   a_r7_wr_step: assert property (@(posedge clk) disable iff (rst)
      (DEP_W'(wr_idx) != wr_last) |=> (wr_idx == $past(wr_idx) + IDX_W'(1)));

   a_r7_wr_wrap: assert property (@(posedge clk) disable iff (rst)
      (DEP_W'(wr_idx) == wr_last) |=> (wr_idx == '0));

endmodule

bind skew_slot_fifo skew_slot_fifo_chk #(.MAX_DEPTH(MAX_DEPTH)) u_chk (
   .clk(clk), .rst(rst), .depth_q(depth_q),
   .wr_idx(wr_idx), .rd_idx(rd_idx), .rd_valid(rd_valid)
);

// File: tb/skew_slot_fifo_bench.sv
module skew_slot_fifo_bench;

   localparam int DW   = 16;
   localparam int MAXD = 8;
   localparam int CW   = $clog2(MAXD + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [CW-1:0] cfg_depth = CW'(4);
   logic          wr_valid = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [DW:0] exp_q[$];

   always #5 clk = ~clk;

   skew_slot_fifo u_skew_slot_fifo (
      .clk(clk), .rst(rst), .cfg_depth(cfg_depth),
      .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   function automatic int model_depth(input int req);
      if (req < 2)    return 2;
      if (req > MAXD) return MAXD;
      return req;
   endfunction

   task automatic check(input string req, input logic ev, input logic [DW-1:0] ed);
      checks++;
      if (rd_valid !== ev || (ev && rd_data !== ed)) begin
         errors++;
         $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                  req, rd_valid, rd_data, ev, ed);
      end
   endtask

   // Hold reset with the requested depth, then release it; the model queue
   // is preloaded with D-1 empty entries to represent the latency.
   task automatic do_reset(input int req_depth);
      @(negedge clk);
      rst = 1'b1;
      wr_valid = 1'b0;
      cfg_depth = CW'(req_depth);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", 1'b0, '0);
      exp_q.delete();
      for (int i = 0; i < model_depth(req_depth) - 1; i++) exp_q.push_back('0);
      rst = 1'b0;
   endtask

   task automatic step(input string req, input logic v, input logic [DW-1:0] d);
      logic [DW:0] e;
      wr_valid = v;
      wr_data  = d;
      @(posedge clk);
      exp_q.push_back({v, d});
      e = exp_q.pop_front();
      @(negedge clk);
      check(req, e[DW], e[DW-1:0]);
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // Default depth, unbroken stream: R1 at start, then R2 latency, R3 order.
      do_reset(4);
      for (int i = 0; i < 16; i++)
         step((i < 3) ? "R1" : ((i < 8) ? "R2" : "R3"), 1'b1, DW'(16'h1000 + i));

      // Holes in the stream: every third cycle empty.
      for (int i = 0; i < 18; i++)
         step("R4", (i % 3) != 0, DW'(16'h2000 + i));

      // Depth request changes mid-stream must be ignored.
      cfg_depth = CW'(2);
      for (int i = 0; i < 10; i++) step("R6", 1'b1, DW'(16'h3000 + i));
      cfg_depth = CW'(7);
      for (int i = 0; i < 10; i++) step("R6", 1'b1, DW'(16'h3100 + i));

      // Odd depth with many wraps.
      do_reset(3);
      for (int i = 0; i < 24; i++)
         step("R7", (i % 5) != 4, DW'(16'h4000 + 3 * i));

      // Below minimum: clamps to two slots.
      do_reset(0);
      for (int i = 0; i < 10; i++) step("R5", 1'b1, DW'(16'h5000 + i));

      // Depth 2 exactly, alternating validity.
      do_reset(2);
      for (int i = 0; i < 10; i++) step("R4", i[0], DW'(16'h5800 + i));

      // Above maximum: clamps to eight slots.
      do_reset(15);
      for (int i = 0; i < 24; i++) step("R5", 1'b1, DW'(16'h6000 - i));

      // Full depth with sparse traffic and ordering.
      do_reset(8);
      for (int i = 0; i < 30; i++)
         step("R3", (i % 4) != 1, DW'(16'h7000 ^ (i * 16'h0111)));

      // Drain with empty cycles.
      for (int i = 0; i < 10; i++) step("R2", 1'b0, '0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule